// File: doc/BRIEF.md
# Eight-bit multi-cycle register CPU

This block is a small processor core for control and teaching datapaths. It has three 8-bit general registers A, B and C, a zero flag and a carry flag. It runs 16-bit instructions held in an internal 256-word instruction store. An internal 256-byte data memory holds variables. One 8-bit input register brings values in from outside, and one 8-bit output register drives values out.

Every instruction takes a fetch step and then one execution step. The execution step is a load step for memory reads, a store step for memory writes, and an ALU step for everything else. Software reaches the core only through its program. A host writes the instruction store over a simple write port while reset is held, releases reset and watches `halted`. The value of `data_out` is the result.

Top module: `acc8_cpu`

## Requirements
- R1: An instruction word is laid out as follows. Bits [15:11] hold the opcode, bits [10:9] the register code (1=A, 2=B, 3=C) and bit [8] the flag V. Bits [7:0] hold the operand, which is an immediate value when V=1; when V=0, operand[1:0] names the source register. Opcodes are numbered 0 to 24 in this order: HALT, LOAD, LDCR, LDZR, LDM, STM, ADD, SUB, AND, OR, NOT, XOR, LSL, LSR, ROL, ROR, IN, OUT, JUMP, BEQ, BNE, BRZ, BNZ, BRC, BNC.
- R2: `rst_n` is an asynchronous, active-low reset. It clears the PC, the registers, both flags, `data_out` and `halted` at once. Internal reset ends on the second rising clock edge after `rst_n` rises.
- R3: Every instruction other than HALT is one FETCH cycle followed by exactly one execution cycle: LOAD for LDM, STORE for STM, ALU otherwise. The fetch of HALT moves straight to the halted state, so a program of k instructions plus HALT halts on edge 2+2k after release (edges counted from 0).
- R4: ADD and SUB write the register plus or minus the source into the register. They set C to the carry out (ADD) or the borrow (SUB), and set Z when the result is zero. AND, OR, XOR and NOT (NOT inverts the register) update Z and leave C unchanged.
- R5: LSL and LSR shift the register by one and fill with zero. ROL and ROR rotate it by one. In all four, C takes the bit shifted out and Z reflects the result.
- R6: LOAD copies the source into the register and leaves both flags unchanged. LDCR clears C only, and LDZR clears Z only.
- R7: LDM reads data memory into the register. STM writes the register into data memory. In both, the address is the source value, either immediate or register.
- R8: The input register samples `data_in` on every clock, and IN copies it into the register. OUT copies the register to `data_out`, and `data_out` changes only through OUT.
- R9: JUMP always goes to operand[7:0]. BRZ and BNZ branch when Z is set or clear, and BRC and BNC branch when C is set or clear, each to operand[7:0]. A SUB that reaches zero followed by BNZ falls through.
- R10: BEQ and BNE compare the register named in bits [10:9] with the register whose code is {V, operand[7]}. When they branch, they go to {0, operand[6:0]}.
- R11: Register code 0 as a destination drops the write. As a source register it reads as zero.
- R12: After HALT, `halted` stays high, the PC holds and no further instruction executes until reset.
- R13: The multiply loop leaves 5 × input mod 256 on `data_out`. The loop reads the input into A, sets B=5 and C=0, adds A to C and subtracts 1 from B until B is zero, then outputs C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | 8 | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to store |
| data_in | input | 8 | External value sampled into the input register |
| data_out | output | 8 | Output register |
| halted | output | 1 | High once HALT has executed |

## Verification
The flags have no port of their own, so they are hardest to observe. The bench reaches them through a ladder of BNC and BNZ branches after each ALU operation, and the ladder turns Z and C into an output byte. The second encoding that is hard to reach is the register-compare branch, whose second register is split across V and operand[7]. Directed programs pick register C as the second register with a target below 128, so a core that decodes the full byte as the address would run off into unwritten memory. Random operands and operations from a fixed seed supply the data values.

// File: rtl/acc8_pkg.sv
`timescale 1ns/1ps
package acc8_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 8;
  localparam int OPC_W       = 5;
  localparam int RSEL_W      = 2;
  localparam int NREGS       = 3;
  localparam int SYNC_STAGES = 2;
  localparam int INSTR_W     = OPC_W + RSEL_W + 1 + DATA_W;
  localparam int MEM_DEPTH   = 1 << ADDR_W;
  localparam int TGT_W       = DATA_W - 1;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT = 5'd0, OP_LOAD, OP_LDCR, OP_LDZR, OP_LDM, OP_STM,
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT, OP_XOR,
    OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_IN, OP_OUT,
    OP_JUMP, OP_BEQ, OP_BNE, OP_BRZ, OP_BNZ, OP_BRC, OP_BNC
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_LOAD, ST_STORE, ST_ALU, ST_HALT
  } step_e;

  typedef struct packed {
    opcode_e             op;
    logic [RSEL_W-1:0]   rd;
    logic                v;
    logic [DATA_W-1:0]   opnd;
  } instr_t;
endpackage

// File: rtl/acc8_rst_sync.sv
`timescale 1ns/1ps
module acc8_rst_sync
  import acc8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [SYNC_STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sr_q[SYNC_STAGES-1];
endmodule

// File: rtl/acc8_regfile.sv
`timescale 1ns/1ps
module acc8_regfile
  import acc8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RSEL_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RSEL_W-1:0] ra0,
  input  logic [RSEL_W-1:0] ra1,
  input  logic [RSEL_W-1:0] ra2,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);
  logic [(NREGS+1)*DATA_W-1:0] bus;

  assign bus[DATA_W-1:0] = '0;

  for (genvar g = 1; g <= NREGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (we && (waddr == RSEL_W'(g)))    q <= wdata;
    end
    assign bus[g*DATA_W +: DATA_W] = q;
  end

  assign rd0 = bus[int'(ra0)*DATA_W +: DATA_W];
  assign rd1 = bus[int'(ra1)*DATA_W +: DATA_W];
  assign rd2 = bus[int'(ra2)*DATA_W +: DATA_W];
endmodule

// File: rtl/acc8_alu.sv
`timescale 1ns/1ps
module acc8_alu
  import acc8_pkg::*;
(
  input  opcode_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              wr,
  output logic              upd_c
);
  logic [DATA_W:0] wide;

  always_comb begin
    wide  = '0;
    res   = a;
    cout  = 1'b0;
    wr    = 1'b1;
    upd_c = 1'b1;
    case (op)
      OP_ADD: begin wide = {1'b0, a} + {1'b0, b}; res = wide[DATA_W-1:0]; cout = wide[DATA_W]; end
      OP_SUB: begin wide = {1'b0, a} - {1'b0, b}; res = wide[DATA_W-1:0]; cout = wide[DATA_W]; end
      OP_AND: begin res = a & b; upd_c = 1'b0; end
      OP_OR:  begin res = a | b; upd_c = 1'b0; end
      OP_XOR: begin res = a ^ b; upd_c = 1'b0; end
      OP_NOT: begin res = ~a;    upd_c = 1'b0; end
      OP_LSL: begin res = {a[DATA_W-2:0], 1'b0};      cout = a[DATA_W-1]; end
      OP_LSR: begin res = {1'b0, a[DATA_W-1:1]};      cout = a[0];        end
      OP_ROL: begin res = {a[DATA_W-2:0], a[DATA_W-1]}; cout = a[DATA_W-1]; end
      OP_ROR: begin res = {a[0], a[DATA_W-1:1]};      cout = a[0];        end
      default: begin wr = 1'b0; upd_c = 1'b0; end
    endcase
  end
endmodule

// File: rtl/acc8_cpu.sv
`timescale 1ns/1ps
module acc8_cpu
  import acc8_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               imem_we,
  input  logic [ADDR_W-1:0]  imem_addr,
  input  logic [INSTR_W-1:0] imem_wdata,
  input  logic [DATA_W-1:0]  data_in,
  output logic [DATA_W-1:0]  data_out,
  output logic               halted
);
  logic rst_s_n;
  acc8_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  // storage arrays: written on the clock, never reset
  logic [INSTR_W-1:0] imem [MEM_DEPTH];
  logic [DATA_W-1:0]  dmem [MEM_DEPTH];

  step_e              state_q, state_d;
  logic [ADDR_W-1:0]  pc_q, pc_d;
  logic               pc_en, ir_en, out_en, dmem_we;
  instr_t             ir_q, fetch_w;
  opcode_e            cur_op;
  logic [DATA_W-1:0]  in_q, out_q;
  logic               zf_q, zf_d, zf_en, cf_q, cf_d, cf_en;
  logic               rf_we;
  logic [DATA_W-1:0]  rf_wdata, ra_val, rb_val, rc_val, src_val, ld_val;
  logic [DATA_W-1:0]  alu_res;
  logic               alu_cout, alu_wr, alu_upd_c;
  logic               take_br;
  logic [ADDR_W-1:0]  br_tgt;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_addr] <= imem_wdata;
  end

  always_ff @(posedge clk) begin
    if (dmem_we) dmem[src_val] <= ra_val;
  end

  assign fetch_w = instr_t'(imem[pc_q]);
  assign cur_op  = ir_q.op;
  assign ld_val  = dmem[src_val];

  acc8_regfile u_rf (
    .clk(clk), .rst_n(rst_s_n),
    .we(rf_we), .waddr(ir_q.rd), .wdata(rf_wdata),
    .ra0(ir_q.rd), .ra1(ir_q.opnd[RSEL_W-1:0]), .ra2({ir_q.v, ir_q.opnd[DATA_W-1]}),
    .rd0(ra_val), .rd1(rb_val), .rd2(rc_val)
  );

  assign src_val = ir_q.v ? ir_q.opnd : rb_val;

  acc8_alu u_alu (
    .op(ir_q.op), .a(ra_val), .b(src_val),
    .res(alu_res), .cout(alu_cout), .wr(alu_wr), .upd_c(alu_upd_c)
  );

  // branch decision
  always_comb begin
    take_br = 1'b0;
    br_tgt  = ir_q.opnd;
    case (ir_q.op)
      OP_JUMP: take_br = 1'b1;
      OP_BEQ:  begin take_br = (ra_val == rc_val); br_tgt = {1'b0, ir_q.opnd[TGT_W-1:0]}; end
      OP_BNE:  begin take_br = (ra_val != rc_val); br_tgt = {1'b0, ir_q.opnd[TGT_W-1:0]}; end
      OP_BRZ:  take_br = zf_q;
      OP_BNZ:  take_br = !zf_q;
      OP_BRC:  take_br = cf_q;
      OP_BNC:  take_br = !cf_q;
      default: take_br = 1'b0;
    endcase
  end

  // next-state and datapath controls
  always_comb begin
    state_d  = state_q;
    pc_en    = 1'b0;
    pc_d     = pc_q;
    ir_en    = 1'b0;
    rf_we    = 1'b0;
    rf_wdata = alu_res;
    zf_en    = 1'b0;
    zf_d     = zf_q;
    cf_en    = 1'b0;
    cf_d     = cf_q;
    out_en   = 1'b0;
    dmem_we  = 1'b0;
    case (state_q)
      ST_FETCH: begin
        ir_en = 1'b1;
        if (fetch_w.op == OP_HALT) begin
          state_d = ST_HALT;
        end else begin
          pc_en = 1'b1;
          pc_d  = pc_q + ADDR_W'(1);
          case (fetch_w.op)
            OP_LDM:  state_d = ST_LOAD;
            OP_STM:  state_d = ST_STORE;
            default: state_d = ST_ALU;
          endcase
        end
      end
      ST_LOAD: begin
        rf_we    = 1'b1;
        rf_wdata = ld_val;
        state_d  = ST_FETCH;
      end
      ST_STORE: begin
        dmem_we = 1'b1;
        state_d = ST_FETCH;
      end
      ST_ALU: begin
        state_d = ST_FETCH;
        case (ir_q.op)
          OP_LOAD: begin rf_we = 1'b1; rf_wdata = src_val; end
          OP_IN:   begin rf_we = 1'b1; rf_wdata = in_q;    end
          OP_OUT:  out_en = 1'b1;
          OP_LDCR: begin cf_en = 1'b1; cf_d = 1'b0; end
          OP_LDZR: begin zf_en = 1'b1; zf_d = 1'b0; end
          default: begin
            if (alu_wr) begin
              rf_we = 1'b1;
              zf_en = 1'b1;
              zf_d  = (alu_res == '0);
              cf_en = alu_upd_c;
              cf_d  = alu_cout;
            end
          end
        endcase
        if (take_br) begin
          pc_en = 1'b1;
          pc_d  = br_tgt;
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= instr_t'('0);
      in_q    <= '0;
      out_q   <= '0;
      zf_q    <= 1'b0;
      cf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      in_q    <= data_in;
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= fetch_w;
      if (out_en) out_q <= ra_val;
      if (zf_en)  zf_q  <= zf_d;
      if (cf_en)  cf_q  <= cf_d;
    end
  end

  assign data_out = out_q;
  assign halted   = (state_q == ST_HALT);
endmodule

// File: rtl/acc8_cpu_chk.sv
`timescale 1ns/1ps
module acc8_cpu_chk
  import acc8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input step_e             state,
  input opcode_e           op,
  input logic [ADDR_W-1:0] pc,
  input logic              zf,
  input logic [DATA_W-1:0] a_val,
  input logic [DATA_W-1:0] b_val,
  input logic [DATA_W-1:0] data_out,
  input logic              halted
);
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R12

  AST_HALT_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc)); // R12

  AST_OUT_ONLY_BY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == ST_ALU && op == OP_OUT) |=> $stable(data_out)); // R8

  AST_EXEC_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD || state == ST_STORE || state == ST_ALU) |=> (state == ST_FETCH)); // R3

  AST_SUB_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ALU && op == OP_SUB && a_val == b_val) |=> zf); // R4
endmodule

bind acc8_cpu acc8_cpu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .op(cur_op), .pc(pc_q),
  .zf(zf_q), .a_val(ra_val), .b_val(src_val), .data_out(data_out), .halted(halted)
);

// File: tb/test_acc8_cpu.sv
`timescale 1ns/1ps
module test_acc8_cpu;
  localparam int O_HALT=0, O_LOAD=1, O_LDCR=2, O_LDZR=3, O_LDM=4, O_STM=5, O_ADD=6, O_SUB=7,
                 O_AND=8, O_OR=9, O_NOT=10, O_XOR=11, O_LSL=12, O_LSR=13, O_ROL=14, O_ROR=15,
                 O_IN=16, O_OUT=17, O_JUMP=18, O_BEQ=19, O_BNE=20, O_BRZ=21, O_BNZ=22,
                 O_BRC=23, O_BNC=24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        imem_we;
  logic [7:0]  imem_addr;
  logic [15:0] imem_wdata;
  logic [7:0]  data_in;
  logic [7:0]  data_out;
  logic        halted;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] pg [64];
  int pn = 0;

  always #2 clk = ~clk;

  acc8_cpu i_acc8_cpu (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .data_in(data_in), .data_out(data_out), .halted(halted)
  );

  function automatic logic [15:0] enc(int op, int rd, int v, int opnd);
    return {op[4:0], rd[1:0], v[0], opnd[7:0]};
  endfunction

  function automatic void put(logic [15:0] w);
    pg[pn] = w;
    pn++;
  endfunction

  // {Z, C, result} expected from the requirements
  function automatic logic [9:0] model(int op, logic [7:0] a, logic [7:0] b);
    logic [8:0] t;
    logic [7:0] r;
    logic c;
    t = '0; r = a; c = 1'b0;
    case (op)
      O_ADD: begin t = {1'b0, a} + {1'b0, b}; r = t[7:0]; c = t[8]; end
      O_SUB: begin t = {1'b0, a} - {1'b0, b}; r = t[7:0]; c = t[8]; end
      O_AND: r = a & b;
      O_OR:  r = a | b;
      O_XOR: r = a ^ b;
      O_NOT: r = ~a;
      O_LSL: begin r = {a[6:0], 1'b0}; c = a[7]; end
      O_LSR: begin r = {1'b0, a[7:1]}; c = a[0]; end
      O_ROL: begin r = {a[6:0], a[7]}; c = a[7]; end
      O_ROR: begin r = {a[0], a[7:1]}; c = a[0]; end
      default: r = a;
    endcase
    return {(r == 8'h00), c, r};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(string req, output int cycles);
    rst_n = 1'b0;
    for (int i = 0; i < pn; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 8'(i); imem_wdata = pg[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    rst_n = 1'b1;
    cycles = 0;
    while (!halted && cycles < 3000) begin
      @(negedge clk);
      cycles++;
    end
    if (!halted) begin
      n_tests++; n_fail++;
      $display("FAIL %s: actual no halt expected halt", req);
    end
  endtask

  task automatic prog_and_check(string req, logic [7:0] exp);
    int cyc;
    run(req, cyc);
    chk(req, data_out, exp);
  endtask

  // flag ladder: output byte = {Z, C} after op and extra word
  task automatic flag_prog(int op, logic [7:0] a, logic [7:0] b, logic [15:0] extra);
    pn = 0;
    put(enc(O_LOAD, 1, 1, a));
    put(enc(op, 1, 1, b));
    put(extra);
    put(enc(O_LOAD, 2, 1, 0));
    put(enc(O_BNC, 0, 1, 6));
    put(enc(O_LOAD, 2, 1, 1));
    put(enc(O_BNZ, 0, 1, 8));
    put(enc(O_LOAD, 3, 1, 2));
    put(enc(O_OR, 2, 0, 3));
    put(enc(O_OUT, 2, 0, 0));
    put(enc(O_HALT, 0, 0, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ops [10] = '{O_ADD, O_SUB, O_AND, O_OR, O_NOT, O_XOR, O_LSL, O_LSR, O_ROL, O_ROR};
    logic [15:0] nop_w;
    int cyc;
    void'($urandom(32'd4711));
    nop_w = enc(O_LOAD, 0, 1, 8'h5A);
    rst_n = 1'b0; imem_we = 1'b0; imem_addr = '0; imem_wdata = '0; data_in = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset data_out", data_out, 8'h00);
    chk("R2 reset halted", {7'd0, halted}, 8'h00);

    // R3 cycle count: 3 instructions + HALT halts on edge 8 -> 9 negedges
    pn = 0;
    put(enc(O_LOAD, 1, 1, 1)); put(enc(O_LOAD, 2, 1, 2));
    put(enc(O_OUT, 1, 0, 0));  put(enc(O_HALT, 0, 0, 0));
    run("R3 timing", cyc);
    chk("R3 cycles to halt", 8'(cyc), 8'd9);

    // R1 register source
    pn = 0;
    put(enc(O_LOAD, 1, 1, 8'h10)); put(enc(O_LOAD, 2, 1, 8'h25));
    put(enc(O_ADD, 1, 0, 2)); put(enc(O_OUT, 1, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R1 reg source add", 8'h35);

    // random ALU results and flags
    for (int i = 0; i < 24; i++) begin
      int op;
      logic [7:0] a, b;
      logic [9:0] m;
      op = ops[$urandom_range(0, 9)];
      a = 8'($urandom); b = 8'($urandom);
      if (i == 0) begin op = O_SUB; a = 8'h20; b = 8'h20; end
      if (i == 1) begin op = O_ADD; a = 8'hFF; b = 8'h01; end
      m = model(op, a, b);
      pn = 0;
      put(enc(O_LOAD, 1, 1, a)); put(enc(op, 1, 1, b));
      put(enc(O_OUT, 1, 0, 0)); put(enc(O_HALT, 0, 0, 0));
      prog_and_check((op >= O_LSL) ? "R5 shift result" : "R4 alu result", m[7:0]);
      flag_prog(op, a, b, nop_w);
      prog_and_check((op >= O_LSL) ? "R5 shift flags" : "R4 R6 alu flags", {6'd0, m[9:8]});
    end

    // R6 flag clears after ADD FF+1 (Z=1,C=1)
    flag_prog(O_ADD, 8'hFF, 8'h01, enc(O_LDCR, 0, 0, 0));
    prog_and_check("R6 LDCR", 8'h02);
    flag_prog(O_ADD, 8'hFF, 8'h01, enc(O_LDZR, 0, 0, 0));
    prog_and_check("R6 LDZR", 8'h01);

    // R7 memory
    pn = 0;
    put(enc(O_LOAD, 1, 1, 8'h3C)); put(enc(O_STM, 1, 1, 8'h80));
    put(enc(O_LDM, 2, 1, 8'h80)); put(enc(O_OUT, 2, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R7 imm address", 8'h3C);
    pn = 0;
    put(enc(O_LOAD, 3, 1, 8'h81)); put(enc(O_LOAD, 2, 1, 8'hC3));
    put(enc(O_STM, 2, 0, 3)); put(enc(O_LDM, 1, 1, 8'h81));
    put(enc(O_OUT, 1, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R7 reg address", 8'hC3);

    // R9 jumps and flag branches
    pn = 0;
    put(enc(O_LOAD, 1, 1, 8'h11)); put(enc(O_JUMP, 0, 1, 3));
    put(enc(O_LOAD, 1, 1, 8'h22)); put(enc(O_OUT, 1, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R9 JUMP", 8'h11);
    pn = 0;
    put(enc(O_LOAD, 1, 1, 3)); put(enc(O_SUB, 1, 1, 3)); put(enc(O_BNZ, 0, 1, 4));
    put(enc(O_LOAD, 2, 1, 8'h55)); put(enc(O_OUT, 2, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R9 BNZ falls through", 8'h55);
    pg[2] = enc(O_BRZ, 0, 1, 4);
    prog_and_check("R9 BRZ taken", 8'h00);
    pn = 0;
    put(enc(O_LOAD, 1, 1, 8'hF0)); put(enc(O_ADD, 1, 1, 8'h20)); put(enc(O_BRC, 0, 1, 4));
    put(enc(O_LOAD, 2, 1, 8'h66)); put(enc(O_OUT, 2, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R9 BRC taken", 8'h00);

    // R10 register compare branches
    pn = 0;
    put(enc(O_LOAD, 1, 1, 7)); put(enc(O_LOAD, 2, 1, 7)); put(enc(O_LOAD, 3, 1, 8'hAA));
    put(enc(O_BEQ, 1, 1, 5)); put(enc(O_LOAD, 3, 1, 8'h11));
    put(enc(O_OUT, 3, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R10 BEQ A,B taken", 8'hAA);
    pg[3] = enc(O_BNE, 1, 1, 5);
    prog_and_check("R10 BNE A,B falls", 8'h11);
    pn = 0;
    put(enc(O_LOAD, 1, 1, 7)); put(enc(O_LOAD, 3, 1, 8)); put(enc(O_LOAD, 2, 1, 8'hAA));
    put(enc(O_BNE, 1, 1, 8'h85)); put(enc(O_LOAD, 2, 1, 8'h11));
    put(enc(O_OUT, 2, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R10 BNE A,C 7-bit target", 8'hAA);

    // R11 register code 0
    pn = 0;
    put(enc(O_LOAD, 1, 1, 9)); put(enc(O_LOAD, 0, 1, 5));
    put(enc(O_OUT, 1, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R11 write dropped", 8'h09);
    pn = 0;
    put(enc(O_LOAD, 2, 1, 8'h33)); put(enc(O_LOAD, 2, 0, 0));
    put(enc(O_OUT, 2, 0, 0)); put(enc(O_HALT, 0, 0, 0));
    prog_and_check("R11 reads zero", 8'h00);

    // R8 R12 halt and output hold
    pn = 0;
    put(enc(O_LOAD, 1, 1, 1)); put(enc(O_OUT, 1, 0, 0)); put(enc(O_LOAD, 1, 1, 3));
    put(enc(O_HALT, 0, 0, 0)); put(enc(O_LOAD, 1, 1, 2)); put(enc(O_OUT, 1, 0, 0));
    prog_and_check("R8 out only by OUT", 8'h01);
    repeat (20) @(negedge clk);
    chk("R12 output after halt", data_out, 8'h01);
    chk("R12 halted sticky", {7'd0, halted}, 8'h01);

    // R13 multiply loop, directed and random inputs
    for (int i = 0; i < 6; i++) begin
      logic [7:0] x;
      x = (i == 0) ? 8'd0 : (i == 1) ? 8'd51 : (i == 2) ? 8'd255 : 8'($urandom);
      data_in = x;
      pn = 0;
      put(enc(O_IN, 1, 0, 0)); put(enc(O_LOAD, 2, 1, 5)); put(enc(O_LOAD, 3, 1, 0));
      put(enc(O_ADD, 3, 0, 1)); put(enc(O_SUB, 2, 1, 1)); put(enc(O_BNZ, 0, 1, 3));
      put(enc(O_OUT, 3, 0, 0)); put(enc(O_HALT, 0, 0, 0));
      prog_and_check("R13 R8 multiply by 5", 8'(x * 5));
    end

    // R2 asynchronous reset from halted
    rst_n = 1'b0;
    #1;
    chk("R2 async reset halted", {7'd0, halted}, 8'h00);
    chk("R2 async reset data_out", data_out, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule